// File: doc/BRIEF.md
# EEPROM Page Writer with Acknowledge Polling

This block is the bus master that stores a contiguous run of bytes into a serial EEPROM on a two-wire bus. A single request carries a three-bit chip select, a word address and a byte count. The block checks that the run fits inside one 64-byte page, then frames the transfer on the bus: a Start condition, the write control byte, two address bytes, the data bytes and a Stop. It checks the slave's acknowledge after every byte. The data bytes are pulled one at a time from a byte-stream input, and a one-cycle strobe marks each byte taken.

After the Stop that starts the device's internal write, the block probes the slave. Each probe is a Start, the write control byte and a Stop. A probe that is not acknowledged is sent again after the bus-free gap. The first probe that is acknowledged ends the request with `done_o`. Any failure ends the request with `err_o`. A failure is a refused address or data byte, a probe count that reaches its cap, or a request that would cross a page. Both lines are open-drain: the block only drives enables that pull SCL or SDA low.

All bus timing comes from the system clock. The low half-phase, high phase and bus-free gap are parameters counted in clock cycles.

Top module: `eeprom_page_writer`

## Requirements
- R1: A write is framed as Start, control byte `{4'b1010, chip[2:0], 1'b0}`, high address byte `{1'b0, addr[14:8]}`, low address byte `addr[7:0]`, the data bytes, then Stop. Every byte goes out MSB first, and a ninth clock follows each byte for the acknowledge.
- R2: For a request of `len` bytes, `byte_taken` pulses exactly once per data byte sent. The byte present on `byte_in` in the cycle the pulse rises is the byte transmitted next.
- R3: If the control, address or data byte is not acknowledged (SDA high during the ninth clock), the block issues a Stop, sends no probe and ends with `err_o`.
- R4: A request is rejected if `len` is 0, or if `addr[5:0] + len` exceeds 64. On rejection `err_o` is high one cycle after the request and `busy_o` stays low. SCL is never pulled low. A run that ends exactly on the page boundary is accepted.
- R5: After the data Stop, the block sends probes of Start, write control byte and Stop, repeating each unacknowledged probe. The first acknowledged probe ends the request with `done_o`.
- R6: If `POLL_MAX` probes in a row are not acknowledged, the request ends with `err_o` and no further probe is sent.
- R7: Each SCL low period lasts at least `2*LOW_HALF` cycles and each high period at least `HIGH_CYC` cycles. SDA changes only in the middle of an SCL low period, except for Start and Stop, which change SDA while SCL is high.
- R8: Between a Stop and the next Start, both lines stay released for at least `BUS_FREE` cycles.
- R9: After reset, and whenever `busy_o` is low, both enables are low. A request that arrives while `busy_o` is high is ignored.
- R10: `done_o` and `err_o` are never high together. Each holds until the next request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_chip | input | 3 | Chip-select bits placed in the control byte |
| req_addr | input | ADDR_W | Word address of the first byte |
| req_len | input | LEN_W | Number of data bytes, 1 to PAGE |
| byte_in | input | 8 | Next data byte of the stream |
| byte_taken | output | 1 | One-cycle strobe: `byte_in` was consumed |
| sda_in | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | Last request finished with an acknowledged probe |
| err_o | output | 1 | Last request was rejected or failed |

## Verification
A rejected request shows its result one clock after the request edge, so the bench samples `err_o` at the next falling edge. An accepted request finishes one clock after its final bus-free gap. Its length depends on the byte count and the number of refused probes, so the bench waits edge by edge for `done_o` or `err_o` and then compares the slave model's log with values computed from the request. The bus model samples both lines at every falling clock edge. From those samples it measures SCL half-periods, the gap between Stop and Start, and each acknowledge slot. The strobe count and the held flags are read at falling edges, away from the edge that updates them.

// File: rtl/eeprom_pw_pkg.sv
package eeprom_pw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BIT,
        ST_STOP,
        ST_FREE
    } pw_state_e;

    // which byte of the frame is currently in the shifter
    typedef enum logic [1:0] {
        SEG_CTRL,
        SEG_AHI,
        SEG_ALO,
        SEG_DATA
    } pw_seg_e;

    // what follows the bus-free gap after a Stop
    typedef enum logic [1:0] {
        AFT_PROBE,
        AFT_OK,
        AFT_FAIL
    } pw_after_e;

    localparam logic [3:0] DEV_CODE = 4'b1010;

    function automatic logic [7:0] ctrl_byte(input logic [2:0] cs);
        return {DEV_CODE, cs, 1'b0};
    endfunction

endpackage

// File: rtl/eeprom_pw_timer.sv
module eeprom_pw_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic [CW-1:0] limit,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    assign expired = !hold && (cnt_q == limit);

    always_comb begin
        if (hold || expired) cnt_d = '0;
        else                 cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/eeprom_pw_range.sv
module eeprom_pw_range #(
    parameter int ADDR_W = 15,
    parameter int LEN_W  = 7,
    parameter int PAGE   = 64
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output logic              fits
);
    localparam int OFF_W = $clog2(PAGE);

    logic [LEN_W:0] end_pos;

    assign end_pos = (LEN_W+1)'(addr[OFF_W-1:0]) + (LEN_W+1)'(len);
    assign fits    = (len != '0) && (end_pos <= (LEN_W+1)'(PAGE));
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
    import eeprom_pw_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int PAGE     = 64,
    parameter int LOW_HALF = 70,
    parameter int HIGH_CYC = 70,
    parameter int BUS_FREE = 140,
    parameter int POLL_MAX = 200,
    localparam int LEN_W   = $clog2(PAGE) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_chip,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [7:0]        byte_in,
    output logic              byte_taken,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);
    localparam int MAX_AB = (LOW_HALF > HIGH_CYC) ? LOW_HALF : HIGH_CYC;
    localparam int MAX_T  = (MAX_AB > BUS_FREE) ? MAX_AB : BUS_FREE;
    localparam int TCW    = $clog2(MAX_T + 1);
    localparam int PCW    = $clog2(POLL_MAX + 1);

    typedef struct packed {
        pw_state_e         state;
        logic [1:0]        phase;
        logic [3:0]        bitcnt;
        logic [7:0]        shreg;
        pw_seg_e           seg;
        pw_after_e         after;
        logic [LEN_W-1:0]  remain;
        logic [ADDR_W-1:0] addr;
        logic [2:0]        chip;
        logic              probing;
        logic [PCW-1:0]    tries;
        logic [1:0]        sync;
        logic              scl_oe;
        logic              sda_oe;
        logic              pop;
        logic              busy;
        logic              done;
        logic              err;
    } regs_t;

    regs_t q, n;

    logic           tick;
    logic           fits;
    logic [TCW-1:0] limit;
    logic           acked;
    logic           go_stop;
    pw_after_e      go_kind;

    eeprom_pw_timer #(.CW(TCW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (q.state == ST_IDLE),
        .limit   (limit),
        .expired (tick)
    );

    eeprom_pw_range #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE(PAGE)) u_range (
        .addr (req_addr),
        .len  (req_len),
        .fits (fits)
    );

    // length of the phase now running, minus one
    always_comb begin
        unique case (q.state)
            ST_START: limit = TCW'(HIGH_CYC - 1);
            ST_BIT,
            ST_STOP:  limit = (q.phase == 2'd2) ? TCW'(HIGH_CYC - 1) : TCW'(LOW_HALF - 1);
            ST_FREE:  limit = TCW'(BUS_FREE - 1);
            default:  limit = '0;
        endcase
    end

    assign acked = !q.sync[1];

    always_comb begin
        n       = q;
        n.pop   = 1'b0;
        n.sync  = {q.sync[0], sda_in};
        go_stop = 1'b0;
        go_kind = AFT_FAIL;

        unique case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (fits) begin
                        n.state   = ST_START;
                        n.busy    = 1'b1;
                        n.done    = 1'b0;
                        n.err     = 1'b0;
                        n.addr    = req_addr;
                        n.chip    = req_chip;
                        n.remain  = req_len;
                        n.probing = 1'b0;
                        n.tries   = '0;
                        n.seg     = SEG_CTRL;
                        n.shreg   = ctrl_byte(req_chip);
                        n.sda_oe  = 1'b1;   // Start: SDA falls with SCL released
                        n.scl_oe  = 1'b0;
                    end else begin
                        n.err  = 1'b1;
                        n.done = 1'b0;
                    end
                end
            end

            ST_START: begin
                if (tick) begin
                    n.state  = ST_BIT;
                    n.phase  = 2'd0;
                    n.bitcnt = 4'd0;
                    n.scl_oe = 1'b1;
                end
            end

            ST_BIT: begin
                if (tick) begin
                    unique case (q.phase)
                        2'd0: begin
                            // middle of SCL low: present the bit, or let go for the acknowledge
                            n.phase  = 2'd1;
                            n.sda_oe = (q.bitcnt == 4'd8) ? 1'b0 : !q.shreg[7];
                        end
                        2'd1: begin
                            n.phase  = 2'd2;
                            n.scl_oe = 1'b0;
                        end
                        default: begin
                            n.phase  = 2'd0;
                            n.scl_oe = 1'b1;
                            if (q.bitcnt != 4'd8) begin
                                n.shreg  = {q.shreg[6:0], 1'b0};
                                n.bitcnt = q.bitcnt + 4'd1;
                            end else begin
                                n.bitcnt = 4'd0;
                                if (q.probing) begin
                                    go_stop = 1'b1;
                                    if (acked) begin
                                        go_kind = AFT_OK;
                                    end else if (q.tries == PCW'(POLL_MAX - 1)) begin
                                        go_kind = AFT_FAIL;
                                    end else begin
                                        go_kind = AFT_PROBE;
                                        n.tries = q.tries + 1'b1;
                                    end
                                end else if (!acked) begin
                                    go_stop = 1'b1;
                                    go_kind = AFT_FAIL;
                                end else begin
                                    unique case (q.seg)
                                        SEG_CTRL: begin
                                            n.seg   = SEG_AHI;
                                            n.shreg = 8'(q.addr >> 8);
                                        end
                                        SEG_AHI: begin
                                            n.seg   = SEG_ALO;
                                            n.shreg = q.addr[7:0];
                                        end
                                        default: begin
                                            if (q.remain == '0) begin
                                                go_stop = 1'b1;
                                                go_kind = AFT_PROBE;
                                            end else begin
                                                n.seg    = SEG_DATA;
                                                n.shreg  = byte_in;
                                                n.pop    = 1'b1;
                                                n.remain = q.remain - 1'b1;
                                            end
                                        end
                                    endcase
                                end
                            end
                        end
                    endcase
                end
            end

            ST_STOP: begin
                if (tick) begin
                    unique case (q.phase)
                        2'd0: begin
                            n.phase  = 2'd1;
                            n.sda_oe = 1'b1;
                        end
                        2'd1: begin
                            n.phase  = 2'd2;
                            n.scl_oe = 1'b0;
                        end
                        default: begin
                            n.phase  = 2'd0;
                            n.sda_oe = 1'b0;   // Stop: SDA rises with SCL released
                            n.state  = ST_FREE;
                        end
                    endcase
                end
            end

            ST_FREE: begin
                if (tick) begin
                    unique case (q.after)
                        AFT_PROBE: begin
                            n.state   = ST_START;
                            n.probing = 1'b1;
                            n.seg     = SEG_CTRL;
                            n.shreg   = ctrl_byte(q.chip);
                            n.sda_oe  = 1'b1;
                        end
                        AFT_OK: begin
                            n.state = ST_IDLE;
                            n.busy  = 1'b0;
                            n.done  = 1'b1;
                        end
                        default: begin
                            n.state = ST_IDLE;
                            n.busy  = 1'b0;
                            n.err   = 1'b1;
                        end
                    endcase
                end
            end

            default: n.state = ST_IDLE;
        endcase

        if (go_stop) begin
            n.state = ST_STOP;
            n.phase = 2'd0;
            n.after = go_kind;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.state   <= ST_IDLE;
            q.seg     <= SEG_CTRL;
            q.after   <= AFT_OK;
            q.sync    <= 2'b11;
        end else begin
            q <= n;
        end
    end

    assign byte_taken = q.pop;
    assign scl_oe     = q.scl_oe;
    assign sda_oe     = q.sda_oe;
    assign busy_o     = q.busy;
    assign done_o     = q.done;
    assign err_o      = q.err;
endmodule

// File: rtl/eeprom_pw_checks.sv
module eeprom_pw_checks #(
    parameter int LOW_HALF = 70,
    parameter int HIGH_CYC = 70
) (
    input logic clk,
    input logic rst_n,
    input logic scl_oe,
    input logic sda_oe,
    input logic busy_o,
    input logic done_o,
    input logic err_o,
    input logic byte_taken
);
    logic [15:0] hi_run, lo_run;

    // consecutive cycles SCL has been released / pulled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= '0;
        end else begin
            if (scl_oe)                 hi_run <= '0;
            else if (hi_run != 16'hFFFF) hi_run <= hi_run + 16'd1;
            if (!scl_oe)                lo_run <= '0;
            else if (lo_run != 16'hFFFF) lo_run <= lo_run + 16'd1;
        end
    end

    a_r7_scl_high_min: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe && !$past(scl_oe)) |-> (32'(hi_run) >= HIGH_CYC));

    a_r7_scl_low_min: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && $past(scl_oe)) |-> (32'(lo_run) >= 2 * LOW_HALF));

    a_r7_sda_quiet_at_scl_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(scl_oe) || $fell(scl_oe)) |-> $stable(sda_oe));

    a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!scl_oe && !sda_oe));

    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    a_r10_done_held: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(done_o) && !done_o) |-> (busy_o || err_o));

    a_r2_take_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        byte_taken |-> busy_o);
endmodule

bind eeprom_page_writer eeprom_pw_checks #(
    .LOW_HALF (LOW_HALF),
    .HIGH_CYC (HIGH_CYC)
) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .byte_taken (byte_taken)
);

// File: tb/eeprom_page_writer_tb.sv
module eeprom_page_writer_tb;
    localparam int ADDR_W   = 15;
    localparam int PAGE     = 64;
    localparam int LOW_HALF = 2;
    localparam int HIGH_CYC = 3;
    localparam int BUS_FREE = 5;
    localparam int POLL_MAX = 4;
    localparam logic [2:0] SLV_ID = 3'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic              req_valid = 1'b0;
    logic [2:0]        req_chip = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [6:0]        req_len = '0;
    logic [7:0]        byte_in;
    logic              byte_taken, sda_in, scl_oe, sda_oe, busy_o, done_o, err_o;

    eeprom_page_writer #(
        .ADDR_W(ADDR_W), .PAGE(PAGE), .LOW_HALF(LOW_HALF),
        .HIGH_CYC(HIGH_CYC), .BUS_FREE(BUS_FREE), .POLL_MAX(POLL_MAX)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chip(req_chip),
        .req_addr(req_addr), .req_len(req_len), .byte_in(byte_in),
        .byte_taken(byte_taken), .sda_in(sda_in), .scl_oe(scl_oe),
        .sda_oe(sda_oe), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    int checks = 0;
    int errs   = 0;

    // byte stream source
    logic [7:0] src [64];
    logic [6:0] pop_cnt = '0;
    assign byte_in = src[pop_cnt[5:0]];

    // bus model
    logic slv_pull = 1'b0;
    wire  scl_line = ~scl_oe;
    wire  sda_line = ~(sda_oe | slv_pull);
    assign sda_in = sda_line;

    logic        prev_scl = 1'b1, prev_sda = 1'b1;
    logic        active = 1'b0, acking = 1'b0, last_ack = 1'b0;
    int          bitc = 0, bidx = 0;
    logic [7:0]  shr = '0;
    int          busy_left = 0, busy_cfg = 0, nack_at = -1;
    int          ctrl_cnt = 0, rx_cnt = 0;
    logic [15:0] rx_addr = '0;
    logic [7:0]  rx [128];
    int          since_stop = 1000000, min_free = 1000000;
    int          run = 0, min_lo = 1000000, min_hi = 1000000, scl_falls = 0;

    always @(negedge clk) begin
        logic scl, sda, ack;
        scl = scl_line;
        sda = sda_line;
        if (byte_taken) pop_cnt <= pop_cnt + 7'd1;
        if (scl == prev_scl) run++;
        else begin
            if (prev_scl) begin if (run < min_hi) min_hi = run; end
            else          begin if (run < min_lo) min_lo = run; end
            run = 1;
        end
        if (!scl && prev_scl) scl_falls++;
        since_stop++;
        if (scl && prev_scl && prev_sda && !sda) begin
            if (since_stop < min_free) min_free = since_stop;
            active = 1'b1; bitc = 0; bidx = 0; acking = 1'b0; slv_pull = 1'b0;
        end
        if (scl && prev_scl && !prev_sda && sda) begin
            since_stop = 0;
            active = 1'b0;
            if (bidx >= 3) begin rx_cnt = bidx - 3; busy_left = busy_cfg; end
        end
        if (scl && !prev_scl && active && !acking && bitc < 8) begin
            shr = {shr[6:0], sda};
            bitc++;
        end
        if (!scl && prev_scl && active) begin
            if (acking) begin
                slv_pull = 1'b0; acking = 1'b0; bitc = 0; bidx++;
                if (!last_ack) active = 1'b0;
            end else if (bitc == 8) begin
                if (bidx == 0) begin
                    ctrl_cnt++;
                    ack = (shr == {4'b1010, SLV_ID, 1'b0});
                    if (ack && busy_left > 0) begin ack = 1'b0; busy_left--; end
                end else if (bidx == 1) begin rx_addr[15:8] = shr; ack = 1'b1; end
                else if (bidx == 2) begin rx_addr[7:0] = shr; ack = 1'b1; end
                else begin
                    rx[(bidx - 3) & 127] = shr;
                    ack = ((bidx - 3) != nack_at);
                end
                slv_pull = ack; acking = 1'b1; last_ack = ack;
            end
        end
        prev_scl = scl;
        prev_sda = sda;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit page_fits(input int addr, input int len);
        return (len >= 1) && ((addr % PAGE) + len <= PAGE);
    endfunction

    function automatic int exp_probes(input bit chip_ok, input int nack, input int len, input int busy_n);
        if (!chip_ok || (nack >= 0 && nack < len)) return 0;
        return (busy_n + 1 < POLL_MAX) ? busy_n + 1 : POLL_MAX;
    endfunction

    task automatic run_write(input int addr, input int len, input logic [2:0] chip,
                             input int busy_n, input int nack, input bit poke);
        bit chip_ok, nacked, good;
        int waited;
        chip_ok = (chip == SLV_ID);
        nacked  = (nack >= 0 && nack < len);
        good    = chip_ok && !nacked && (busy_n < POLL_MAX);
        for (int i = 0; i < 64; i++) src[i] = 8'($urandom);
        busy_cfg = busy_n; busy_left = 0; nack_at = nack; ctrl_cnt = 0; rx_cnt = 0;
        rx_addr = '1;
        pop_cnt = '0;
        @(negedge clk);
        req_valid = 1'b1; req_chip = chip; req_addr = ADDR_W'(addr); req_len = 7'(len);
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 busy after accept", int'(busy_o), 1);
        waited = 0;
        while (!(done_o || err_o) && waited < 30000) begin
            @(negedge clk);
            waited++;
            if (poke && waited == 40) begin
                req_valid = 1'b1; req_addr = ADDR_W'(addr ^ 32'h0100);
            end
            if (poke && waited == 41) req_valid = 1'b0;
        end
        check("R5 finished in time", int'(waited < 30000), 1);
        check("R10 done flag", int'(done_o), int'(good));
        check("R3 R6 err flag", int'(err_o), int'(!good));
        check("R5 R6 probe count", (ctrl_cnt > 0) ? ctrl_cnt - 1 : 0,
              exp_probes(chip_ok, nack, len, busy_n));
        check("R2 strobes", int'(pop_cnt), !chip_ok ? 0 : (nacked ? nack + 1 : len));
        if (chip_ok && !nacked) begin
            check("R1 address bytes", int'(rx_addr), addr & 32'h7FFF);
            check("R1 byte count", rx_cnt, len);
            for (int i = 0; i < len; i++)
                check($sformatf("R1 R2 data[%0d]", i), int'(rx[i]), int'(src[i]));
        end
        repeat (5) @(negedge clk);
        check("R10 flag held", int'(done_o || err_o), 1);
        check("R10 exclusive", int'(done_o && err_o), 0);
        check("R9 lines idle", int'(scl_oe || sda_oe), 0);
    endtask

    task automatic run_reject(input int addr, input int len);
        int falls0;
        falls0 = scl_falls;
        check("R4 model agrees", int'(page_fits(addr, len)), 0);
        @(negedge clk);
        req_valid = 1'b1; req_chip = SLV_ID; req_addr = ADDR_W'(addr); req_len = 7'(len);
        @(negedge clk);
        req_valid = 1'b0;
        check("R4 err next cycle", int'(err_o), 1);
        check("R4 not busy", int'(busy_o), 0);
        check("R10 done cleared", int'(done_o), 0);
        repeat (20) @(negedge clk);
        check("R4 bus untouched", scl_falls - falls0, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errs++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R9 reset scl", int'(scl_oe), 0);
        check("R9 reset sda", int'(sda_oe), 0);
        check("R9 reset busy", int'(busy_o), 0);
        check("R10 reset done", int'(done_o), 0);
        check("R10 reset err", int'(err_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        run_write(32'h0040, 1, SLV_ID, 0, -1, 0);
        run_write(32'h1FC0, 64, SLV_ID, 2, -1, 0);
        run_write(32'h7FFF, 1, SLV_ID, 1, -1, 0);
        run_write(32'h233C, 4, SLV_ID, 0, -1, 1);
        run_reject(32'h233C, 5);
        run_reject(32'h0100, 0);
        run_reject(32'h0100, 65);
        run_write(32'h0200, 8, 3'd2, 0, -1, 0);
        run_write(32'h0300, 6, SLV_ID, 0, 2, 0);
        run_write(32'h0400, 3, SLV_ID, 6, -1, 0);
        for (int t = 0; t < 10; t++) begin
            int a, l;
            a = int'($urandom_range(32'h7FFF, 0));
            l = int'($urandom_range(PAGE - (a % PAGE), 1));
            run_write(a, l, SLV_ID, int'($urandom_range(3, 0)), -1, 0);
        end

        check("R7 shortest SCL low", int'(min_lo >= 2 * LOW_HALF), 1);
        check("R7 shortest SCL high", int'(min_hi >= HIGH_CYC), 1);
        check("R8 shortest bus-free gap", int'(min_free >= BUS_FREE), 1);
        if (min_lo < 2 * LOW_HALF) $display("FAIL R7 low actual=%0d expected=%0d", min_lo, 2 * LOW_HALF);
        if (min_free < BUS_FREE) $display("FAIL R8 gap actual=%0d expected=%0d", min_free, BUS_FREE);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule